// File: doc/BRIEF.md
# ASID-Tagged Translation Cache

This block keeps a small set of recent virtual-to-physical page mappings so that a memory access can be translated without walking the page tables. Every slot can hold any page. A slot maps either a 4 KB page or a 2 MB page. Each slot also records the address-space tag that was current when it was written, and a lookup only uses slots whose tag equals the current one. A process switch is therefore a write of a new tag: slots that belong to other address spaces stay stored, and they hit again when their tag becomes current.

A lookup presents a virtual address. One cycle later the block returns hit or miss, the physical address and the page size. After a miss, the page table walker delivers the mapping on the fill port. The fill takes the lowest free slot. If no slot is free, a round-robin pointer picks the victim. A fill never creates a second slot for a page that is already held. Software control is a tag write, a full flush and an invalidate of one page.

Top module: `asid_tlb`

## Requirements
- R1: A lookup presented with `lk_valid` high at clock edge t produces `out_valid` high after edge t+1. The result covers the lookup alone, and `out_valid` is low in every cycle that follows a cycle with no lookup.
- R2: A lookup that matches no valid slot of the current tag returns `out_hit`=0, `out_pa`=0 and `out_large`=0.
- R3: A fill stores the tag that is current in its own cycle. A slot hits only while its stored tag equals the current tag.
- R4: A tag write via `ctx_we` takes effect at the next edge and clears no slots. Slots written under an earlier tag hit again, with their original frame, once that tag is current again.
- R5: `flush_all` clears every slot of every tag. A fill in the same cycle as a flush is dropped.
- R6: `kill_valid` clears the slot of the current tag whose page covers `kill_va`. Slots of other pages, and the same page under other tags, keep their state.
- R7: A 4 KB slot compares `va[31:12]` and returns `{pfn, va[11:0]}`. A 2 MB slot (`fill_large`=1) compares only `va[31:21]`, returns `{pfn[19:9], va[20:0]}` and sets `out_large`.
- R8: A fill goes into the lowest-numbered free slot whenever a free slot exists, even if the victim pointer points at an occupied slot.
- R9: When every slot is full, a fill replaces the slot at the victim pointer. The pointer is 0 after reset and advances by one, wrapping at the depth, on each such replacement only.
- R10: A fill whose page overlaps a slot of the current tag overwrites that slot instead of adding a second one. Lookups then return the new frame, and at most one slot ever matches a lookup.
- R11: A fill and an invalidate in the same cycle, where the fill's page covers `kill_va`, leave the page unmapped: the invalidate wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a two-stage synchronizer |
| lk_valid | input | 1 | Lookup request |
| lk_va | input | 32 | Lookup virtual address |
| out_valid | output | 1 | Lookup result valid, one cycle after the request |
| out_hit | output | 1 | Translation found |
| out_pa | output | 32 | Translated physical address |
| out_large | output | 1 | Hit slot maps a 2 MB page |
| fill_valid | input | 1 | Fill from the page table walker |
| fill_va | input | 32 | Virtual address of the page being filled |
| fill_pfn | input | 20 | Physical frame number (4 KB units) |
| fill_large | input | 1 | Fill maps a 2 MB page |
| ctx_we | input | 1 | Load a new current address-space tag |
| ctx_asid | input | 8 | New address-space tag |
| flush_all | input | 1 | Invalidate every slot |
| kill_valid | input | 1 | Invalidate one page under the current tag |
| kill_va | input | 32 | Address inside the page to invalidate |

## Verification
The lookup table probes addresses inside and outside 4 KB and 2 MB pages: both ends of a page, the neighbouring page and the top of the address space. These probes separate wrong offset widths, wrong compare ranges and wrong frame splicing. Directed sequences switch tags back and forth and fill the same page under two tags, which shows whether matching depends on the tag and whether tags survive a switch. Filling every slot and then removing one page shows whether free slots are preferred over the victim pointer and whether that pointer only moves on a replacement. Same-cycle flush/fill and invalidate/fill pairs check the priority rules.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  // Offset widths of the two supported page sizes
  localparam int OFS_SMALL = 12;
  localparam int OFS_LARGE = 21;

  // Where a fill lands
  typedef enum logic [1:0] {
    SLOT_NONE   = 2'd0,
    SLOT_MATCH  = 2'd1,
    SLOT_FREE   = 2'd2,
    SLOT_VICTIM = 2'd3
  } slot_src_e;
endpackage

// File: rtl/tlb_tag_cmp.sv
// Page compare: the stored tag against an address, at the coarser granule
// when the slot is large or the caller forces it.
module tlb_tag_cmp #(
  parameter int VA_W = 32
) (
  input  logic [VA_W-tlb_pkg::OFS_SMALL-1:0] ent_vpn,
  input  logic                               ent_large,
  input  logic                               coarse,
  input  logic [VA_W-1:0]                    va,
  output logic                               same
);
  localparam int LO_W = tlb_pkg::OFS_LARGE - tlb_pkg::OFS_SMALL;
  localparam int VPN_W = VA_W - tlb_pkg::OFS_SMALL;

  always_comb begin
    if (ent_large || coarse) same = (ent_vpn[VPN_W-1:LO_W] == va[VA_W-1:tlb_pkg::OFS_LARGE]);
    else                     same = (ent_vpn == va[VA_W-1:tlb_pkg::OFS_SMALL]);
  end
endmodule

// File: rtl/tlb_first_one.sv
// Lowest-index set bit finder.
module tlb_first_one #(
  parameter int N  = 64,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/tlb_rr_ptr.sv
// Round-robin victim pointer, advanced only when a full cache replaces a slot.
module tlb_rr_ptr #(
  parameter int N  = 64,
  parameter int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          arst_n,
  input  logic          adv,
  output logic [IW-1:0] ptr
);
  logic [IW-1:0] ptr_d;

  always_comb begin
    ptr_d = ptr;
    if (adv) ptr_d = (ptr == IW'(N - 1)) ? '0 : ptr + 1'b1;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) ptr <= '0;
    else if (adv) ptr <= ptr_d;
  end
endmodule

// File: rtl/asid_tlb.sv
module asid_tlb #(
  parameter int VA_W   = 32,
  parameter int PA_W   = 32,
  parameter int ASID_W = 8,
  parameter int DEPTH  = 64
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          lk_valid,
  input  logic [VA_W-1:0]               lk_va,
  output logic                          out_valid,
  output logic                          out_hit,
  output logic [PA_W-1:0]               out_pa,
  output logic                          out_large,
  input  logic                          fill_valid,
  input  logic [VA_W-1:0]               fill_va,
  input  logic [PA_W-tlb_pkg::OFS_SMALL-1:0] fill_pfn,
  input  logic                          fill_large,
  input  logic                          ctx_we,
  input  logic [ASID_W-1:0]             ctx_asid,
  input  logic                          flush_all,
  input  logic                          kill_valid,
  input  logic [VA_W-1:0]               kill_va
);
  import tlb_pkg::*;

  localparam int VPN_W = VA_W - OFS_SMALL;
  localparam int PFN_W = PA_W - OFS_SMALL;
  localparam int LO_W  = OFS_LARGE - OFS_SMALL;
  localparam int IW    = $clog2(DEPTH);

  // Reset synchronizer: assert asynchronously, release on the clock
  logic [1:0] rs_q;
  logic       arst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign arst_n = rs_q[1];

  // Slot storage
  logic [DEPTH-1:0]  val_q, val_d;
  logic [VPN_W-1:0]  vpn_q  [DEPTH];
  logic [PFN_W-1:0]  pfn_q  [DEPTH];
  logic [ASID_W-1:0] asid_q [DEPTH];
  logic [DEPTH-1:0]  large_q;
  logic [ASID_W-1:0] cur_asid;

  // Per-slot compares
  logic [DEPTH-1:0] lk_tag, kl_tag, fl_tag, own;
  logic [DEPTH-1:0] lk_match, kl_match, fl_match;

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    assign own[i] = val_q[i] && (asid_q[i] == cur_asid);

    tlb_tag_cmp #(.VA_W(VA_W)) u_lk (
      .ent_vpn(vpn_q[i]), .ent_large(large_q[i]), .coarse(1'b0),
      .va(lk_va), .same(lk_tag[i]));
    tlb_tag_cmp #(.VA_W(VA_W)) u_kl (
      .ent_vpn(vpn_q[i]), .ent_large(large_q[i]), .coarse(1'b0),
      .va(kill_va), .same(kl_tag[i]));
    tlb_tag_cmp #(.VA_W(VA_W)) u_fl (
      .ent_vpn(vpn_q[i]), .ent_large(large_q[i]), .coarse(fill_large),
      .va(fill_va), .same(fl_tag[i]));

    assign lk_match[i] = own[i] && lk_tag[i];
    assign kl_match[i] = own[i] && kl_tag[i];
    assign fl_match[i] = own[i] && fl_tag[i];
  end

  // Does the incoming fill cover the page being invalidated?
  logic fill_hits_kill;
  tlb_tag_cmp #(.VA_W(VA_W)) u_fk (
    .ent_vpn(fill_va[VA_W-1:OFS_SMALL]), .ent_large(fill_large), .coarse(1'b0),
    .va(kill_va), .same(fill_hits_kill));

  logic fill_go;
  assign fill_go = fill_valid && !flush_all && !(kill_valid && fill_hits_kill);

  // Slot selection for a fill
  logic          m_found, f_found, lk_found;
  logic [IW-1:0] m_idx, f_idx, lk_idx, vic_idx, tgt_idx;
  slot_src_e     src;

  tlb_first_one #(.N(DEPTH), .IW(IW)) u_pick_match (.req(fl_match), .found(m_found), .idx(m_idx));
  tlb_first_one #(.N(DEPTH), .IW(IW)) u_pick_free  (.req(~val_q),   .found(f_found), .idx(f_idx));
  tlb_first_one #(.N(DEPTH), .IW(IW)) u_pick_hit   (.req(lk_match), .found(lk_found), .idx(lk_idx));

  always_comb begin
    if (!fill_go)     begin src = SLOT_NONE;   tgt_idx = '0;      end
    else if (m_found) begin src = SLOT_MATCH;  tgt_idx = m_idx;   end
    else if (f_found) begin src = SLOT_FREE;   tgt_idx = f_idx;   end
    else              begin src = SLOT_VICTIM; tgt_idx = vic_idx; end
  end

  tlb_rr_ptr #(.N(DEPTH), .IW(IW)) u_victim (
    .clk(clk), .arst_n(arst_n), .adv(src == SLOT_VICTIM), .ptr(vic_idx));

  // Valid-bit next state: flush, then invalidate, then fill
  always_comb begin
    val_d = val_q;
    if (flush_all) begin
      val_d = '0;
    end else begin
      if (kill_valid) val_d = val_d & ~kl_match;
      if (fill_go) begin
        val_d          = val_d & ~fl_match;
        val_d[tgt_idx] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) val_q <= '0;
    else         val_q <= val_d;
  end

  // Payload, written only by a fill
  always_ff @(posedge clk) begin
    if (fill_go) begin
      vpn_q[tgt_idx]   <= fill_va[VA_W-1:OFS_SMALL];
      pfn_q[tgt_idx]   <= fill_pfn;
      asid_q[tgt_idx]  <= cur_asid;
      large_q[tgt_idx] <= fill_large;
    end
  end

  // Current tag
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)     cur_asid <= '0;
    else if (ctx_we) cur_asid <= ctx_asid;
  end

  // Lookup result
  logic [PA_W-1:0] pa_d;
  logic [PFN_W-1:0] sel_pfn;
  logic             sel_large;

  always_comb begin
    sel_pfn   = pfn_q[lk_idx];
    sel_large = large_q[lk_idx];
    if (!lk_valid || !lk_found) pa_d = '0;
    else if (sel_large)         pa_d = {sel_pfn[PFN_W-1:LO_W], lk_va[OFS_LARGE-1:0]};
    else                        pa_d = {sel_pfn, lk_va[OFS_SMALL-1:0]};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      out_valid <= 1'b0;
      out_hit   <= 1'b0;
      out_pa    <= '0;
      out_large <= 1'b0;
    end else begin
      out_valid <= lk_valid;
      out_hit   <= lk_valid && lk_found;
      out_pa    <= pa_d;
      out_large <= lk_valid && lk_found && sel_large;
    end
  end
endmodule

// File: rtl/asid_tlb_chk.sv
module asid_tlb_chk #(
  parameter int DEPTH  = 64,
  parameter int ASID_W = 8
) (
  input logic              clk,
  input logic              run_n,
  input logic [DEPTH-1:0]  lk_match,
  input logic [DEPTH-1:0]  val_q,
  input logic [ASID_W-1:0] cur_asid,
  input logic              lk_valid,
  input logic              out_valid,
  input logic              out_hit,
  input logic              out_large,
  input logic              fill_valid,
  input logic              flush_all,
  input logic              kill_valid,
  input logic              ctx_we,
  input logic [ASID_W-1:0] ctx_asid
);
  // R10: never two slots answering one lookup
  p_unique_match_r10: assert property (@(posedge clk) disable iff (!run_n)
    $onehot0(lk_match));

  // R5: flush empties the cache
  p_flush_empty_r5: assert property (@(posedge clk) disable iff (!run_n)
    flush_all |=> (val_q == '0));

  // R4: tag write lands next cycle
  p_ctx_load_r4: assert property (@(posedge clk) disable iff (!run_n)
    ctx_we |=> (cur_asid == $past(ctx_asid)));

  // R1: one result per lookup, one cycle later
  p_result_follows_r1: assert property (@(posedge clk) disable iff (!run_n)
    lk_valid |=> out_valid);
  p_no_spurious_r1: assert property (@(posedge clk) disable iff (!run_n)
    !lk_valid |=> !out_valid);

  // R2: hit only on a valid result
  p_hit_in_result_r2: assert property (@(posedge clk) disable iff (!run_n)
    out_hit |-> out_valid);

  // R7: page size is reported only for a hit
  p_large_on_hit_r7: assert property (@(posedge clk) disable iff (!run_n)
    out_large |-> out_hit);

  // R8: an accepted fill leaves at least one occupied slot
  p_fill_occupies_r8: assert property (@(posedge clk) disable iff (!run_n)
    (fill_valid && !flush_all && !kill_valid) |=> (val_q != '0));
endmodule

bind asid_tlb asid_tlb_chk #(.DEPTH(DEPTH), .ASID_W(ASID_W)) u_chk (
  .clk(clk), .run_n(rs_q[1]), .lk_match(lk_match), .val_q(val_q),
  .cur_asid(cur_asid), .lk_valid(lk_valid), .out_valid(out_valid),
  .out_hit(out_hit), .out_large(out_large), .fill_valid(fill_valid),
  .flush_all(flush_all), .kill_valid(kill_valid), .ctx_we(ctx_we),
  .ctx_asid(ctx_asid));

// File: tb/tb_asid_tlb.sv
`timescale 1ns/1ps
module tb_asid_tlb;
  localparam int DEPTH = 64;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        lk_valid, fill_valid, fill_large, ctx_we, flush_all, kill_valid;
  logic [31:0] lk_va, fill_va, kill_va;
  logic [19:0] fill_pfn;
  logic [7:0]  ctx_asid;
  logic        out_valid, out_hit, out_large;
  logic [31:0] out_pa;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  asid_tlb dut (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_va(lk_va),
    .out_valid(out_valid), .out_hit(out_hit), .out_pa(out_pa), .out_large(out_large),
    .fill_valid(fill_valid), .fill_va(fill_va), .fill_pfn(fill_pfn), .fill_large(fill_large),
    .ctx_we(ctx_we), .ctx_asid(ctx_asid), .flush_all(flush_all),
    .kill_valid(kill_valid), .kill_va(kill_va));

  // {va, hit, pa, large}
  localparam logic [65:0] VEC [8] = '{
    {32'h0040_3123, 1'b1, 32'h0ABC_D123, 1'b0},
    {32'h0040_4123, 1'b0, 32'h0000_0000, 1'b0},
    {32'h107F_FFFC, 1'b1, 32'h123F_FFFC, 1'b1},
    {32'h1060_0000, 1'b1, 32'h1220_0000, 1'b1},
    {32'h1080_0000, 1'b0, 32'h0000_0000, 1'b0},
    {32'hFFFF_FFFF, 1'b1, 32'h0000_1FFF, 1'b0},
    {32'h0000_0000, 1'b0, 32'h0000_0000, 1'b0},
    {32'h0040_3FFF, 1'b1, 32'h0ABC_DFFF, 1'b0}
  };

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic idle();
    lk_valid = 0; fill_valid = 0; ctx_we = 0; flush_all = 0; kill_valid = 0;
  endtask

  task automatic look(input logic [31:0] va);
    @(negedge clk); lk_valid = 1; lk_va = va;
    @(negedge clk); lk_valid = 0;
  endtask

  task automatic expect_tr(input string tag, input logic [31:0] va,
                           input logic hit, input logic [31:0] pa, input logic lg);
    look(va);
    chk(tag, {out_valid, out_hit, out_large, out_pa}, {1'b1, hit, lg, pa});
  endtask

  task automatic fill(input logic [31:0] va, input logic [19:0] pfn, input logic lg);
    @(negedge clk); fill_valid = 1; fill_va = va; fill_pfn = pfn; fill_large = lg;
    @(negedge clk); fill_valid = 0;
  endtask

  task automatic set_asid(input logic [7:0] a);
    @(negedge clk); ctx_we = 1; ctx_asid = a;
    @(negedge clk); ctx_we = 0;
  endtask

  task automatic kill(input logic [31:0] va);
    @(negedge clk); kill_valid = 1; kill_va = va;
    @(negedge clk); kill_valid = 0;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual running expected finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idle();
    lk_va = 0; fill_va = 0; kill_va = 0; fill_pfn = 0; fill_large = 0; ctx_asid = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // Reset state (R1, R2)
    chk("R1 idle after reset", {63'd0, out_valid}, 64'd0);
    expect_tr("R2 empty cache misses", 32'h0040_3123, 1'b0, 32'h0, 1'b0);

    // Populate under tag 5
    set_asid(8'd5);
    fill(32'h0040_3000, 20'h0ABCD, 1'b0);
    fill(32'h1060_0000, 20'h12345, 1'b1);
    fill(32'hFFFF_F000, 20'h00001, 1'b0);

    // Table walk (R1, R2, R7)
    for (int i = 0; i < 8; i++) begin
      expect_tr($sformatf("R7 vector %0d", i), VEC[i][65:34], VEC[i][33], VEC[i][32:1], VEC[i][0]);
    end

    // R3: other tag does not see tag-5 slots
    set_asid(8'd9);
    expect_tr("R3 foreign tag misses", 32'h0040_3123, 1'b0, 32'h0, 1'b0);
    fill(32'h0040_3000, 20'h00777, 1'b0);
    expect_tr("R3 own tag hits", 32'h0040_3123, 1'b1, 32'h0077_7123, 1'b0);

    // R4: switching back restores the old translation
    set_asid(8'd5);
    expect_tr("R4 old tag restored", 32'h0040_3123, 1'b1, 32'h0ABC_D123, 1'b0);

    // R6: invalidate one page under tag 5
    kill(32'h0040_3ABC);
    expect_tr("R6 killed page misses", 32'h0040_3123, 1'b0, 32'h0, 1'b0);
    expect_tr("R6 other page kept", 32'h1070_0004, 1'b1, 32'h1230_0004, 1'b1);
    set_asid(8'd9);
    expect_tr("R6 other tag kept", 32'h0040_3123, 1'b1, 32'h0077_7123, 1'b0);
    set_asid(8'd5);

    // R10: refill of a held page overwrites
    fill(32'hFFFF_F000, 20'h00002, 1'b0);
    expect_tr("R10 overwritten frame", 32'hFFFF_FFFF, 1'b1, 32'h0000_2FFF, 1'b0);

    // R11: invalidate and fill of the same page together
    @(negedge clk);
    fill_valid = 1; fill_va = 32'h0050_0000; fill_pfn = 20'h00055; fill_large = 0;
    kill_valid = 1; kill_va = 32'h0050_0010;
    @(negedge clk); idle();
    expect_tr("R11 invalidate wins", 32'h0050_0000, 1'b0, 32'h0, 1'b0);

    // R5: flush with a simultaneous fill
    @(negedge clk);
    flush_all = 1; fill_valid = 1; fill_va = 32'h0060_0000; fill_pfn = 20'h00066; fill_large = 0;
    @(negedge clk); idle();
    expect_tr("R5 fill dropped by flush", 32'h0060_0000, 1'b0, 32'h0, 1'b0);
    expect_tr("R5 large slot flushed", 32'h1060_0000, 1'b0, 32'h0, 1'b0);
    set_asid(8'd9);
    expect_tr("R5 other tag flushed", 32'h0040_3123, 1'b0, 32'h0, 1'b0);
    set_asid(8'd5);

    // R8/R9: replacement order
    for (int i = 0; i < DEPTH; i++) begin
      fill(32'h0100_0000 + (i << 12), 20'h00100 + 20'(i), 1'b0);
    end
    expect_tr("R8 all slots held", 32'h0100_0000 + ((DEPTH - 1) << 12) + 32'h10, 1'b1,
              {20'h00100 + 20'(DEPTH - 1), 12'h010}, 1'b0);
    fill(32'h0200_0000, 20'h00AAA, 1'b0);
    expect_tr("R9 slot 0 replaced", 32'h0100_0000, 1'b0, 32'h0, 1'b0);
    expect_tr("R9 new page held", 32'h0200_0004, 1'b1, 32'h00AA_A004, 1'b0);
    kill(32'h0100_5000);
    fill(32'h0200_1000, 20'h00BBB, 1'b0);
    expect_tr("R8 free slot preferred", 32'h0100_1008, 1'b1, 32'h0010_1008, 1'b0);
    expect_tr("R8 refilled page held", 32'h0200_1008, 1'b1, 32'h00BB_B008, 1'b0);
    fill(32'h0200_2000, 20'h00CCC, 1'b0);
    expect_tr("R9 pointer advanced once", 32'h0100_1008, 1'b0, 32'h0, 1'b0);
    expect_tr("R9 next slot kept", 32'h0100_2008, 1'b1, 32'h0010_2008, 1'b0);

    // R1: no result without a request
    @(negedge clk);
    chk("R1 no request no result", {63'd0, out_valid}, 64'd0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule